// File: doc/BRIEF.md
# Fetch-Stage Instruction Cache with Victim Store

This block supplies instructions to the fetch stage of a 32-bit pipeline. Each fetch presents a word-aligned address. On a hit the instruction comes back one cycle later with a valid pulse. The cache has two parts that are looked up together. The first is a direct-mapped main store of one word per line. The second is a small fully associative victim store that keeps lines recently pushed out of the main store.

When the main store misses but the victim store hits, the two lines trade places. The instruction still returns with hit latency. When both miss, the block stalls the fetch stage by lowering `req_ready` and issues a single-word read on a ready/valid memory port. It then writes the returned word into the main store and moves the displaced line into the victim store. A flush input empties both stores in one cycle.

Top module: `fetch_icache`

## Requirements
- R1: After reset, `resp_valid` and `mem_req_valid` are low and `req_ready` is high.
- R2: A fetch is accepted on a clock edge where `req_valid` and `req_ready` are both high. The main-store index is address bits [9:2] and the tag is bits [31:10]. On a hit, `resp_valid` is high for one cycle after the accepting edge, and `resp_data` holds the cached word.
- R3: Hits on consecutive cycles each complete in one cycle. `req_ready` stays high and no memory read is issued.
- R4: A fetch that misses in both stores raises `mem_req_valid` with `mem_req_addr` equal to the fetch address with bits [1:0] cleared. Address and valid hold steady until `mem_req_ready`. Only one read is ever outstanding, and `req_ready` is low until the response has been delivered.
- R5: In the cycle after `mem_resp_valid` is sampled high, `resp_valid` is high and `resp_data` equals the returned word. The word is installed, so the next fetch of that address hits.
- R6: A valid main line displaced by a refill enters the victim store. A later fetch of it hits with one-cycle latency and no memory read.
- R7: A victim hit swaps the victim entry with the conflicting main line. Both addresses then hit without a memory read.
- R8: The victim store holds 4 entries that are replaced in FIFO order. After five displacements into it, the oldest is gone and the four newest remain.
- R9: A flush clears every valid bit in both stores in one cycle. `req_ready` is low during the flush cycle, and every following fetch misses.
- R10: When a flush coincides with the cycle in which the refill word arrives, the word is still returned on `resp_data`, but it is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines in both stores |
| req_valid | input | 1 | Fetch request present |
| req_addr | input | 32 | Word-aligned fetch address |
| req_ready | output | 1 | Cache can accept a fetch this cycle |
| resp_valid | output | 1 | Instruction valid pulse |
| resp_data | output | 32 | Returned instruction |
| mem_req_valid | output | 1 | Refill read request |
| mem_req_addr | output | 32 | Refill word address |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Refill data present |
| mem_resp_data | input | 32 | Refill word |

## Verification
The flush can land in the same cycle as the arrival of a refill word. In that cycle, delivering the word and installing the line pull in opposite directions. The bench takes the memory port under direct control and raises `mem_resp_valid` together with `flush`. It judges the outcome at the ports: the response must carry the memory word, and a second fetch of the same address must issue a fresh memory read. The swap-versus-refill ordering is exercised by chains of conflicting addresses, where the memory read count shows which fetches hit.

// File: rtl/icache_pkg.sv
package icache_pkg;
   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_WAIT = 2'd2
   } fill_state_e;
endpackage

// File: rtl/icache_main_array.sv
module icache_main_array #(
   parameter int LINES  = 256,
   parameter int TAG_W  = 22,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [TAG_W-1:0]  rd_tag,
   output logic [DATA_W-1:0] rd_data,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [DATA_W-1:0] wr_data
);
   logic [LINES-1:0]  valid_q;
   logic [TAG_W-1:0]  tag_q  [LINES];
   logic [DATA_W-1:0] data_q [LINES];

   if ((1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)           valid_q <= '0;
      else if (flush)       valid_q <= '0;
      else if (wr_en)       valid_q[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en && !flush) begin
         tag_q[wr_idx]  <= wr_tag;
         data_q[wr_idx] <= wr_data;
      end
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_data  = data_q[rd_idx];

   // R9: one flush cycle empties the main store
   p_flush_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
endmodule

// File: rtl/icache_victim_buf.sv
module icache_victim_buf #(
   parameter int VICTIMS = 4,
   parameter int WADDR_W = 30,
   parameter int DATA_W  = 32,
   localparam int PTR_W  = (VICTIMS > 1) ? $clog2(VICTIMS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [WADDR_W-1:0] lk_waddr,
   output logic               lk_hit,
   output logic [PTR_W-1:0]   lk_way,
   output logic [DATA_W-1:0]  lk_data,
   input  logic               sw_en,
   input  logic [PTR_W-1:0]   sw_way,
   input  logic               sw_valid,
   input  logic [WADDR_W-1:0] sw_waddr,
   input  logic [DATA_W-1:0]  sw_data,
   input  logic               ins_en,
   input  logic [WADDR_W-1:0] ins_waddr,
   input  logic [DATA_W-1:0]  ins_data
);
   logic [VICTIMS-1:0] valid_q;
   logic [VICTIMS-1:0] hit_vec;
   logic [WADDR_W-1:0] waddr_q [VICTIMS];
   logic [DATA_W-1:0]  data_q  [VICTIMS];
   logic [PTR_W-1:0]   ptr_q;

   if (VICTIMS < 1) begin : g_bad_victims
      $error("VICTIMS must be at least one");
   end

   for (genvar i = 0; i < VICTIMS; i++) begin : g_entry
      assign hit_vec[i] = valid_q[i] && (waddr_q[i] == lk_waddr);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            valid_q[i] <= 1'b0;
         end else if (flush) begin
            valid_q[i] <= 1'b0;
         end else if (sw_en && sw_way == PTR_W'(i)) begin
            valid_q[i] <= sw_valid;
            waddr_q[i] <= sw_waddr;
            data_q[i]  <= sw_data;
         end else if (ins_en && ptr_q == PTR_W'(i)) begin
            valid_q[i] <= 1'b1;
            waddr_q[i] <= ins_waddr;
            data_q[i]  <= ins_data;
         end
      end
   end

   always_comb begin
      lk_way  = '0;
      lk_data = '0;
      for (int i = VICTIMS - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            lk_way  = PTR_W'(i);
            lk_data = data_q[i];
         end
      end
   end
   assign lk_hit = |hit_vec;

   if (VICTIMS > 1) begin : g_fifo_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)                 ptr_q <= '0;
         else if (ins_en && !flush)  ptr_q <= (ptr_q == PTR_W'(VICTIMS - 1)) ? '0 : ptr_q + 1'b1;
      end

      // R8: each insertion advances the FIFO position
      p_fifo_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
         (ins_en && !flush) |=> (ptr_q != $past(ptr_q)));
   end else begin : g_single
      assign ptr_q = '0;
   end

   // R7: a word address is never held twice
   p_unique_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

   // R9: one flush cycle empties the victim store
   p_flush_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (valid_q == '0));
endmodule

// File: rtl/fetch_icache.sv
module fetch_icache
   import icache_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int DATA_W  = 32,
   parameter int LINES   = 256,
   parameter int VICTIMS = 4,
   localparam int IDX_W   = $clog2(LINES),
   localparam int TAG_W   = ADDR_W - IDX_W - 2,
   localparam int WADDR_W = ADDR_W - 2,
   localparam int PTR_W   = (VICTIMS > 1) ? $clog2(VICTIMS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              flush,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              req_ready,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_data,
   output logic              mem_req_valid,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_req_ready,
   input  logic              mem_resp_valid,
   input  logic [DATA_W-1:0] mem_resp_data
);
   if (TAG_W < 1) begin : g_bad_addr
      $error("ADDR_W too small for LINES");
   end

   fill_state_e        state_q;
   logic [WADDR_W-1:0] miss_waddr_q;
   logic               disp_valid_q;
   logic [WADDR_W-1:0] disp_waddr_q;
   logic [DATA_W-1:0]  disp_data_q;
   logic               resp_valid_q;
   logic [DATA_W-1:0]  resp_data_q;

   logic [IDX_W-1:0]   req_idx;
   logic [TAG_W-1:0]   req_tag;
   logic [WADDR_W-1:0] req_waddr;
   logic               unused_low_bits;

   logic               m_valid, m_hit;
   logic [TAG_W-1:0]   m_tag;
   logic [DATA_W-1:0]  m_data;
   logic               v_hit;
   logic [PTR_W-1:0]   v_way;
   logic [DATA_W-1:0]  v_data;

   logic accept, do_miss, do_swap, refill_done, install;
   logic               mw_en;
   logic [IDX_W-1:0]   mw_idx;
   logic [TAG_W-1:0]   mw_tag;
   logic [DATA_W-1:0]  mw_data;

   assign req_waddr       = req_addr[ADDR_W-1:2];
   assign req_idx         = req_addr[IDX_W+1:2];
   assign req_tag         = req_addr[ADDR_W-1:IDX_W+2];
   assign unused_low_bits = ^req_addr[1:0];

   assign req_ready   = (state_q == FS_IDLE) && !flush;
   assign accept      = req_valid && req_ready;
   assign m_hit       = m_valid && (m_tag == req_tag);
   assign do_swap     = accept && !m_hit && v_hit;
   assign do_miss     = accept && !m_hit && !v_hit;
   assign refill_done = (state_q == FS_WAIT) && mem_resp_valid;
   assign install     = refill_done && !flush;

   always_comb begin
      mw_en   = do_swap || install;
      mw_idx  = req_idx;
      mw_tag  = req_tag;
      mw_data = v_data;
      if (!do_swap) begin
         mw_idx  = miss_waddr_q[IDX_W-1:0];
         mw_tag  = miss_waddr_q[WADDR_W-1:IDX_W];
         mw_data = mem_resp_data;
      end
   end

   icache_main_array #(
      .LINES (LINES),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
   ) main_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (flush),
      .rd_idx  (req_idx),
      .rd_valid(m_valid),
      .rd_tag  (m_tag),
      .rd_data (m_data),
      .wr_en   (mw_en),
      .wr_idx  (mw_idx),
      .wr_tag  (mw_tag),
      .wr_data (mw_data)
   );

   icache_victim_buf #(
      .VICTIMS(VICTIMS),
      .WADDR_W(WADDR_W),
      .DATA_W (DATA_W)
   ) victim_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .lk_waddr (req_waddr),
      .lk_hit   (v_hit),
      .lk_way   (v_way),
      .lk_data  (v_data),
      .sw_en    (do_swap),
      .sw_way   (v_way),
      .sw_valid (m_valid),
      .sw_waddr ({m_tag, req_idx}),
      .sw_data  (m_data),
      .ins_en   (install && disp_valid_q),
      .ins_waddr(disp_waddr_q),
      .ins_data (disp_data_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
      end else begin
         unique case (state_q)
            FS_IDLE: if (do_miss)        state_q <= FS_REQ;
            FS_REQ:  if (mem_req_ready)  state_q <= FS_WAIT;
            FS_WAIT: if (mem_resp_valid) state_q <= FS_IDLE;
            default:                     state_q <= FS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_valid_q <= 1'b0;
      end else if (flush) begin
         disp_valid_q <= 1'b0;
      end else if (do_miss) begin
         disp_valid_q <= m_valid;
      end
   end

   always_ff @(posedge clk) begin
      if (do_miss) begin
         miss_waddr_q <= req_waddr;
         disp_waddr_q <= {m_tag, req_idx};
         disp_data_q  <= m_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         resp_valid_q <= 1'b0;
         resp_data_q  <= '0;
      end else begin
         resp_valid_q <= (accept && (m_hit || v_hit)) || refill_done;
         if (refill_done)  resp_data_q <= mem_resp_data;
         else if (m_hit)   resp_data_q <= m_data;
         else if (v_hit)   resp_data_q <= v_data;
      end
   end

   assign resp_valid    = resp_valid_q;
   assign resp_data     = resp_data_q;
   assign mem_req_valid = (state_q == FS_REQ);
   assign mem_req_addr  = {miss_waddr_q, 2'b00};

   // R3: an accepted hit answers on the next cycle
   p_hit_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && (m_hit || v_hit)) |=> resp_valid);

   // R4: request held steady until taken
   p_hold_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   // R4: fetch stalled while a read is outstanding
   p_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_valid |-> !req_ready);

   // R5: refill word forwarded one cycle later
   p_refill_resp_r5: assert property (@(posedge clk) disable iff (!rst_n)
      refill_done |=> (resp_valid && resp_data == $past(mem_resp_data)));
endmodule

// File: tb/fetch_icache_tb_top.sv
`timescale 1ns/1ps
module fetch_icache_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flush = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_ready;
   logic        resp_valid;
   logic [31:0] resp_data;
   logic        mem_req_valid;
   logic [31:0] mem_req_addr;
   logic        mem_req_ready = 1'b0;
   logic        mem_resp_valid = 1'b0;
   logic [31:0] mem_resp_data = '0;

   int n_checks = 0;
   int n_fail = 0;
   int n_memreq = 0;
   int unstable = 0;
   logic [31:0] last_req_addr = '0;
   bit manual = 1'b0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fetch_icache dut_i (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
      .resp_valid(resp_valid), .resp_data(resp_data),
      .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
      .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
      .mem_resp_data(mem_resp_data)
   );

   function automatic logic [31:0] memword(input logic [31:0] a);
      return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ 32'h5A5A_0F0F;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   // automatic memory model with varying acceptance delay
   initial begin
      forever begin
         @(negedge clk);
         if (!manual) begin
            mem_resp_valid = 1'b0;
            mem_req_ready  = 1'b0;
            if (mem_req_valid) begin
               logic [31:0] first;
               first = mem_req_addr;
               last_req_addr = first;
               n_memreq++;
               repeat (n_memreq % 3) begin
                  @(negedge clk);
                  if (!mem_req_valid || mem_req_addr != first) unstable++;
               end
               mem_req_ready = 1'b1;
               @(negedge clk);
               mem_req_ready = 1'b0;
               @(negedge clk);
               mem_resp_valid = 1'b1;
               mem_resp_data  = memword(first);
            end
         end
      end
   end

   task automatic fetch(input logic [31:0] a, input bit exp_miss, input string req);
      int lat;
      int n0;
      n0 = n_memreq;
      @(negedge clk);
      req_valid = 1'b1;
      req_addr  = a;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      lat = 1;
      while (!resp_valid && lat < 60) begin
         @(negedge clk);
         lat++;
      end
      check(resp_valid && resp_data == memword(a), req, "fetched word", resp_data, memword(a));
      check((n_memreq != n0) == exp_miss, req, "memory read issued",
            32'(n_memreq - n0), 32'(exp_miss));
      if (!exp_miss) check(lat == 1, req, "hit latency", 32'(lat), 32'd1);
      else begin
         check(last_req_addr == {a[31:2], 2'b00} && unstable == 0, "R4",
               "request address", last_req_addr, {a[31:2], 2'b00});
      end
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      #1;
      check(req_ready == 1'b0, "R9", "req_ready during flush", 32'(req_ready), 32'd0);
      @(negedge clk);
      flush = 1'b0;
   endtask

   // {expect_miss, address}; idx 0x40 shared by 0x100, 0x500, 0xFFFFFD00
   localparam logic [32:0] VEC [10] = '{
      {1'b1, 32'h0000_0100},   // R5 cold miss
      {1'b0, 32'h0000_0100},   // R2 hit
      {1'b1, 32'h0000_0104},   // R5
      {1'b0, 32'h0000_0104},   // R2
      {1'b1, 32'h0000_0500},   // R6 displaces 0x100
      {1'b0, 32'h0000_0100},   // R6 victim hit, swap
      {1'b0, 32'h0000_0500},   // R7 swapped line found
      {1'b0, 32'h0000_0104},   // R2 other index untouched
      {1'b1, 32'hFFFF_FD00},   // R2 tag upper bits differ
      {1'b0, 32'h0000_0500}    // R7
   };

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(resp_valid == 1'b0, "R1", "resp_valid in reset", 32'(resp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1 && mem_req_valid == 1'b0, "R1", "ready/req after reset",
            {30'd0, req_ready, mem_req_valid}, 32'h2);

      for (int i = 0; i < 10; i++) begin
         fetch(VEC[i][31:0], VEC[i][32], "R2/R5/R6/R7 vector");
      end

      // R3: back-to-back hits on 0x104 then 0x500
      begin
         int n0;
         n0 = n_memreq;
         @(negedge clk);
         req_valid = 1'b1;
         req_addr  = 32'h0000_0104;
         check(req_ready == 1'b1, "R3", "ready before first hit", 32'(req_ready), 32'd1);
         @(negedge clk);
         check(resp_valid && resp_data == memword(32'h104), "R3", "first back-to-back",
               resp_data, memword(32'h104));
         check(req_ready == 1'b1, "R3", "ready between hits", 32'(req_ready), 32'd1);
         req_addr = 32'h0000_0500;
         @(negedge clk);
         req_valid = 1'b0;
         check(resp_valid && resp_data == memword(32'h500), "R3", "second back-to-back",
               resp_data, memword(32'h500));
         check(n_memreq == n0, "R3", "no memory read", 32'(n_memreq - n0), 32'd0);
      end

      // R9: flush empties everything
      do_flush();
      fetch(32'h0000_0500, 1'b1, "R9 after flush");
      fetch(32'h0000_0104, 1'b1, "R9 after flush");

      // R8: FIFO victim replacement, conflict chain on index 0x40
      do_flush();
      for (int k = 0; k < 6; k++) begin
         fetch(32'h0000_0100 + 32'(k) * 32'h400, 1'b1, "R8 chain fill");
      end
      fetch(32'h0000_0100, 1'b1, "R8 oldest evicted");
      fetch(32'h0000_1100, 1'b0, "R8 newest kept");
      fetch(32'h0000_0500, 1'b1, "R8 overwritten by FIFO");

      // R10: flush together with refill arrival
      @(negedge clk);
      manual = 1'b1;
      mem_req_ready  = 1'b0;
      mem_resp_valid = 1'b0;
      req_valid = 1'b1;
      req_addr  = 32'h0000_2220;
      @(negedge clk);
      req_valid = 1'b0;
      check(mem_req_valid == 1'b1 && mem_req_addr == 32'h0000_2220, "R4", "manual request",
            mem_req_addr, 32'h0000_2220);
      check(req_ready == 1'b0, "R4", "stalled during refill", 32'(req_ready), 32'd0);
      mem_req_ready = 1'b1;
      @(negedge clk);
      mem_req_ready  = 1'b0;
      mem_resp_valid = 1'b1;
      mem_resp_data  = memword(32'h0000_2220);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      mem_resp_valid = 1'b0;
      check(resp_valid && resp_data == memword(32'h2220), "R10", "word delivered under flush",
            resp_data, memword(32'h2220));
      manual = 1'b0;
      fetch(32'h0000_2220, 1'b1, "R10 not installed");
      fetch(32'h0000_2220, 1'b0, "R5 installed after refill");

      report();
   end
endmodule